// File: doc/BRIEF.md
# Tri-State PWM Gate Control Sequencer

This block is the digital control core of one phase of a synchronous buck power stage. A controller delivers a three-level PWM command (high, low or a mid level), already decoded into a two-bit code, together with an active-low brake request. A supply-good flag and a zero-current comparator output arrive from analog circuitry. From these the block produces registered enables for the high-side and low-side gate drivers. A programmable dead time guarantees that one switch is fully off before the other is turned on.

The mid PWM level has two meanings. The sequencer picks one of them once per power-up. In the default braking mode a mid level turns both switches off. If the brake input is seen low after the supply becomes good, or was low just before it did, the block latches diode-emulation mode. That latch is released only when supply-good drops. In diode-emulation mode a mid level first removes the high-side enable. The low-side switch is then held on until the zero-current comparator fires, so that no negative inductor current flows. The comparator is only honoured after a blanking window measured from low-side turn-on. If no zero crossing arrives within a timeout, the low-side switch is released and the switch node floats.

Top module: `pwm_gate_seq`

## Requirements
- R1: While `rst` is high or `supply_ok` is low, both gate enables are low one clock edge later, and the diode-emulation latch is cleared.
- R2: `hs_en` and `ls_en` are never high together. Every rise of either enable is preceded by at least `DEAD_CYC` consecutive cycles with both low. When the enable changes directly from one gate to the other, the second gate rises on the `DEAD_CYC+2`-th edge after the new command.
- R3: With the brake released, PWM code 2'b01 (high) drives `hs_en` high and `ls_en` low, and code 2'b00 (low) drives `ls_en` high and `hs_en` low. From a state where both enables have been low for at least `DEAD_CYC` cycles, the new enable rises on the first edge.
- R4: While `brake_n` is low, both enables are low from the next edge on, whatever the PWM code or mode.
- R5: In braking mode (the default after power-up), the mid PWM codes 2'b10 and 2'b11 make both enables low.
- R6: Diode-emulation mode is latched when `brake_n` is sampled low on `LATCH_CYC` consecutive edges while `supply_ok` is high. A shorter low pulse leaves braking mode in place.
- R7: Diode-emulation mode is also latched when `brake_n` was low on the last edge before `supply_ok` was sampled high, even if it is released together with the supply rising.
- R8: Once latched, diode-emulation mode persists while `supply_ok` stays high and is cleared only by `supply_ok` going low.
- R9: In diode-emulation mode, a mid code arriving while `hs_en` is high clears `hs_en` on the next edge, and then raises `ls_en` after the dead time.
- R10: In diode-emulation mode under a mid code, `zc_det` is ignored during the first `BLANK_CYC` cycles of low-side on-time. A qualifying `zc_det` sample clears `ls_en` two edges later, and it stays low while the mid code persists.
- R11: In diode-emulation mode, if no qualifying zero crossing occurs, `ls_en` falls on the `TIMEOUT_CYC+1`-th edge after the mid code is first applied and stays low while the mid code persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag; low models a supply that is down |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 10 or 11 mid |
| brake_n | input | 1 | Active-low brake request, also the mode-select strap |
| zc_det | input | 1 | Zero-current comparator output, active high |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The hardest states to reach from the ports are the two ends of a diode-emulation episode. One is a zero crossing that arrives inside the blanking window, which must be ignored. The other is the timeout expiring with no crossing at all. The bench first latches the mode through both strap paths. It then enters the mid level from a high-side pulse, so that the low-side on-time starts at a known edge after the dead time. A one-cycle comparator pulse is placed inside the blanking window, and a second episode is run with the comparator held quiet on a reduced timeout. The mode-latch paths are exercised by dropping and restoring `supply_ok` around brake pulses of different lengths.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic [1:0] {
    REQ_OFF = 2'd0,
    REQ_HS  = 2'd1,
    REQ_LS  = 2'd2
  } gate_req_e;

  localparam logic [1:0] PWM_CODE_LOW  = 2'b00;
  localparam logic [1:0] PWM_CODE_HIGH = 2'b01;

  function automatic logic pwm_is_mid(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/pgs_mode_latch.sv
module pgs_mode_latch #(
  parameter int LATCH_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic brake_n,
  output logic de_mode
);

  localparam int LW = $clog2(LATCH_CYC + 1);

  logic [LW-1:0] low_cnt;
  logic          pre_low;
  logic          long_low;

  assign long_low = !brake_n && (low_cnt >= LW'(LATCH_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      pre_low <= 1'b0;
      de_mode <= 1'b0;
    end else if (!supply_ok) begin
      low_cnt <= '0;
      de_mode <= 1'b0;
      pre_low <= !brake_n;
    end else begin
      if (brake_n)
        low_cnt <= '0;
      else if (low_cnt < LW'(LATCH_CYC))
        low_cnt <= low_cnt + 1'b1;
      if (pre_low || long_low)
        de_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/pgs_de_timer.sv
module pgs_de_timer #(
  parameter int BLANK_CYC   = 15,
  parameter int TIMEOUT_CYC = 2800
) (
  input  logic clk,
  input  logic rst,
  input  logic mid_de,
  input  logic ls_on,
  input  logic zc_det,
  output logic de_done
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [BW-1:0] on_age;
  logic [TW-1:0] ep_cnt;
  logic          blank_over;
  logic          zc_hit;
  logic          time_up;

  assign blank_over = (on_age >= BW'(BLANK_CYC));
  assign zc_hit     = zc_det && ls_on && blank_over;
  assign time_up    = (ep_cnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !ls_on)
      on_age <= '0;
    else if (!blank_over)
      on_age <= on_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !mid_de) begin
      ep_cnt  <= '0;
      de_done <= 1'b0;
    end else if (!de_done) begin
      ep_cnt <= ep_cnt + 1'b1;
      if (time_up || zc_hit)
        de_done <= 1'b1;
    end
  end

endmodule

// File: rtl/pgs_gate_drv.sv
module pgs_gate_drv
  import pwm_gate_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      supply_ok,
  input  gate_req_e req,
  output logic      hs_q,
  output logic      ls_q
);

  localparam int DW = $clog2(DEAD_CYC + 1);

  logic [DW-1:0] dcnt;
  logic          dead_met;

  assign dead_met = (dcnt >= DW'(DEAD_CYC));

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
      dcnt <= '0;
    end else begin
      case (req)
        REQ_HS: begin
          if (ls_q) begin
            ls_q <= 1'b0;
            dcnt <= '0;
          end else if (!hs_q) begin
            if (dead_met) hs_q <= 1'b1;
            else          dcnt <= dcnt + 1'b1;
          end
        end
        REQ_LS: begin
          if (hs_q) begin
            hs_q <= 1'b0;
            dcnt <= '0;
          end else if (!ls_q) begin
            if (dead_met) ls_q <= 1'b1;
            else          dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (hs_q || ls_q) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
            dcnt <= '0;
          end else if (!dead_met) begin
            dcnt <= dcnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
  import pwm_gate_pkg::*;
#(
  parameter int DEAD_CYC    = 2,
  parameter int BLANK_CYC   = 15,
  parameter int TIMEOUT_CYC = 2800,
  parameter int LATCH_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic [1:0] pwm_lvl,
  input  logic       brake_n,
  input  logic       zc_det,
  output logic       hs_en,
  output logic       ls_en
);

  logic      de_mode;
  logic      de_done;
  logic      mid_de;
  gate_req_e req;

  assign mid_de = supply_ok && brake_n && de_mode && pwm_is_mid(pwm_lvl);

  always_comb begin
    if (!brake_n)
      req = REQ_OFF;
    else if (pwm_is_mid(pwm_lvl))
      req = (de_mode && !de_done) ? REQ_LS : REQ_OFF;
    else if (pwm_lvl == PWM_CODE_HIGH)
      req = REQ_HS;
    else
      req = REQ_LS;
  end

  pgs_mode_latch #(.LATCH_CYC(LATCH_CYC)) mode_i (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .brake_n   (brake_n),
    .de_mode   (de_mode)
  );

  pgs_de_timer #(.BLANK_CYC(BLANK_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .mid_de  (mid_de),
    .ls_on   (ls_en),
    .zc_det  (zc_det),
    .de_done (de_done)
  );

  pgs_gate_drv #(.DEAD_CYC(DEAD_CYC)) drv_i (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .req       (req),
    .hs_q      (hs_en),
    .ls_q      (ls_en)
  );

endmodule

// File: rtl/pwm_gate_seq_chk.sv
module pwm_gate_seq_chk #(
  parameter int DEAD_CYC = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       brake_n,
  input logic [1:0] pwm_lvl,
  input logic       hs_en,
  input logic       ls_en,
  input logic       de_mode
);

  logic [7:0] off_run;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok)
      off_run <= '0;
    else if (hs_en || ls_en)
      off_run <= '0;
    else if (off_run != 8'hFF)
      off_run <= off_run + 1'b1;
  end

  // R2
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  // R2
  dead_hs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> ($past(off_run) >= 8'(DEAD_CYC)));

  // R2
  dead_ls_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> ($past(off_run) >= 8'(DEAD_CYC)));

  // R1
  supply_off_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!hs_en && !ls_en && !de_mode));

  // R4
  brake_off_chk: assert property (@(posedge clk) disable iff (rst)
    !brake_n |=> (!hs_en && !ls_en));

  // R5
  brake_mode_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (!de_mode && pwm_lvl[1] && brake_n && supply_ok) |=> (!hs_en && !ls_en));

  // R8
  de_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (de_mode && supply_ok) |=> de_mode);

  // R3
  high_no_ls_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_lvl == 2'b01) |=> !ls_en);

  // R9
  mid_no_hs_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_lvl[1] |=> !hs_en);

endmodule

bind pwm_gate_seq pwm_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .brake_n   (brake_n),
  .pwm_lvl   (pwm_lvl),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .de_mode   (de_mode)
);

// File: tb/pwm_gate_seq_tb_top.sv
module pwm_gate_seq_tb_top;

  localparam int DEAD  = 2;
  localparam int BLANK = 15;
  localparam int TMO   = 120;
  localparam int LATCH = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic [1:0] pwm_lvl = 2'b00;
  logic       brake_n = 1'b1;
  logic       zc_det = 1'b0;
  logic       hs_en;
  logic       ls_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_gate_seq #(
    .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .TIMEOUT_CYC(TMO), .LATCH_CYC(LATCH)
  ) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .pwm_lvl(pwm_lvl),
    .brake_n(brake_n), .zc_det(zc_det), .hs_en(hs_en), .ls_en(ls_en)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_gates(input string tag, input logic eh, input logic el);
    chk(tag, {hs_en, ls_en}, {eh, el});
  endtask

  // edges until the chosen enable is high (want_hs) or low-side falls (fall)
  task automatic edges_until(input int what, output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (n < 1000 &&
               !((what == 0 && hs_en) || (what == 1 && ls_en) || (what == 2 && !ls_en)));
  endtask

  function automatic logic [1:0] exp_steady(input logic [1:0] code, input logic de);
    if (code[1])          return de ? 2'b01 : 2'b00;
    else if (code == 2'b01) return 2'b10;
    else                  return 2'b01;
  endfunction

  initial begin
    int n;
    // R1 reset state
    step(3);
    chk_gates("R1 reset", 1'b0, 1'b0);
    rst = 1'b0;
    pwm_lvl = 2'b01;
    step(5);
    chk_gates("R1 supply low", 1'b0, 1'b0);

    supply_ok = 1'b1;
    pwm_lvl = 2'b00;
    step(10);

    // R3 R5 sweep in braking mode
    for (int c = 0; c < 4; c++) begin
      pwm_lvl = 2'(c);
      step(8);
      chk("R3_R5 brake-mode sweep", {hs_en, ls_en}, exp_steady(2'(c), 1'b0));
    end

    // R3 from idle: first edge
    pwm_lvl = 2'b01;
    edges_until(0, n);
    chk("R3 hs from idle edges", n, 1);
    // R2 direct switch hs -> ls
    pwm_lvl = 2'b00;
    step(1);
    chk_gates("R2 hs released first", 1'b0, 1'b0);
    edges_until(1, n);
    chk("R2 ls after dead time edges", n + 1, DEAD + 2);
    pwm_lvl = 2'b01;
    edges_until(0, n);
    chk("R2 hs after dead time edges", n, DEAD + 2);

    // R4 short brake pulse; R6 too short to latch
    brake_n = 1'b0;
    step(1);
    chk_gates("R4 brake forces off", 1'b0, 1'b0);
    brake_n = 1'b1;
    step(8);
    chk_gates("R4 brake release resumes", 1'b1, 1'b0);
    pwm_lvl = 2'b10;
    step(8);
    chk_gates("R6 short pulse keeps braking mode", 1'b0, 1'b0);

    // R6 latch diode emulation with LATCH-cycle low
    brake_n = 1'b0;
    step(LATCH);
    brake_n = 1'b1;
    pwm_lvl = 2'b01;
    step(8);
    chk_gates("R6 hs after latch", 1'b1, 1'b0);

    // R9 R11 timeout episode
    zc_det = 1'b0;
    pwm_lvl = 2'b10;
    step(1);
    chk_gates("R9 hs off first", 1'b0, 1'b0);
    edges_until(1, n);
    chk("R9 ls on after dead time edges", n + 1, DEAD + 2);
    edges_until(2, n);
    chk("R11 timeout edge", n + DEAD + 2, TMO + 1);
    step(20);
    chk_gates("R11 stays floating", 1'b0, 1'b0);

    // R10 zero crossing held from the start
    pwm_lvl = 2'b01;
    step(8);
    zc_det = 1'b1;
    pwm_lvl = 2'b10;
    edges_until(1, n);
    chk("R10 ls on with zc high", n, DEAD + 2);
    edges_until(2, n);
    chk("R10 ls on-time with blanking", n, BLANK + 2);
    step(10);
    chk_gates("R10 stays off in mid", 1'b0, 1'b0);

    // R10 pulse inside blanking ignored
    zc_det = 1'b0;
    pwm_lvl = 2'b01;
    step(8);
    pwm_lvl = 2'b11;
    edges_until(1, n);
    step(1);
    zc_det = 1'b1;
    step(1);
    zc_det = 1'b0;
    step(20);
    chk_gates("R10 blanked pulse ignored", 1'b0, 1'b1);
    zc_det = 1'b1;
    step(1);
    chk_gates("R10 one edge after zc", 1'b0, 1'b1);
    step(1);
    chk_gates("R10 two edges after zc", 1'b0, 1'b0);
    zc_det = 1'b0;

    // R3 sweep in diode-emulation mode
    for (int c = 0; c < 4; c++) begin
      pwm_lvl = 2'(c);
      step(8);
      chk("R3_R9 de-mode sweep", {hs_en, ls_en}, exp_steady(2'(c), 1'b1));
    end

    // R4 brake in diode-emulation mode
    pwm_lvl = 2'b01;
    step(8);
    brake_n = 1'b0;
    step(1);
    chk_gates("R4 brake in de mode", 1'b0, 1'b0);
    brake_n = 1'b1;

    // R8 supply loss clears mode; R1
    supply_ok = 1'b0;
    step(3);
    chk_gates("R1 supply drop", 1'b0, 1'b0);
    supply_ok = 1'b1;
    step(8);
    pwm_lvl = 2'b10;
    step(8);
    chk_gates("R8 mode cleared by supply loss", 1'b0, 1'b0);

    // R7 strap low across supply rise
    supply_ok = 1'b0;
    brake_n = 1'b0;
    pwm_lvl = 2'b01;
    step(4);
    supply_ok = 1'b1;
    brake_n = 1'b1;
    step(10);
    chk_gates("R7 hs after strap power-up", 1'b1, 1'b0);
    pwm_lvl = 2'b10;
    step(DEAD + 4);
    chk_gates("R7 de mode latched by strap", 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule